// File: doc/BRIEF.md
# Page-Register Address Mapper

This block widens the 16-bit logical address of an 8-bit processor into a 21-bit physical address. The logical space is cut into eight 8 KB windows. Each window has its own 8-bit page register, and that register names which 8 KB page of the 2 MB physical space the window shows. The low 13 address bits pass through unchanged. The three top logical bits choose the window, and the chosen register supplies the upper eight physical bits.

Software changes the mapping with two dedicated transfer operations. A load strobe carries an 8-bit one-hot mask and a data byte, and it writes that byte into every selected register on the same clock edge. A fetch strobe returns one register's value, registered, on a read data bus. Translation is combinational by default, and a parameter can add an output register. On reset every page register holds page 0x00. The top window, which holds the processor's reset vector at 0xFFFE/0xFFFF, therefore starts out mapped onto physical page 0.

Top module: `ptm_mapper`

## Requirements
- R1: While reset is asserted and after it is released, every page register holds 0x00 and `rdata_o` is 0x00. Logical 0xFFFE therefore translates to physical 0x001FFE.
- R2: Physical bits 12..0 always equal logical bits 12..0.
- R3: Physical bits 20..13 equal the page register whose index is logical bits 15..13. In the default combinational mode this holds in the same cycle.
- R4: When `wr_en_i` is high at a rising clock edge, every register k with `mask_i[k]` = 1 takes `wdata_i`. Registers whose mask bit is 0 keep their value.
- R5: When `rd_en_i` is high at a rising clock edge, `rdata_o` takes the value of the lowest-numbered register whose mask bit is set. The new value is visible after that edge. While `rd_en_i` is low, `rdata_o` holds its value.
- R6: A fetch with an all-zero mask returns 0x00.
- R7: When a load and a fetch hit the same register in one cycle, the fetch returns the value from before the load. Translation in the load cycle uses the old value, and it uses the new value from the next cycle on.
- R8: A load with `wr_en_i` low, or with an all-zero mask, has no effect on any register. This is observed through later fetches and translations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| laddr_i | input | 16 | Logical address |
| phys_o | output | 21 | Physical address |
| wr_en_i | input | 1 | Load strobe for the page registers |
| rd_en_i | input | 1 | Fetch strobe for the page registers |
| mask_i | input | 8 | One-hot (or multi-hot) register select, bit k = register k |
| wdata_i | input | 8 | Byte to load |
| rdata_o | output | 8 | Fetched register value |

## Verification
Three things can fall on the same edge: a load, a fetch and a translation, all aimed at the same register. The bench provokes this with directed cycles in which load and fetch share a mask while the address points into the loaded window, and again with random cycles in which both strobes are often high with overlapping masks. It judges the outcome against a reference model that is updated only after the edge. The fetch and the same-cycle translation must therefore show the old value, and the translation in the next cycle must show the new one.

// File: rtl/ptm_pkg.sv
`timescale 1ns/1ps
package ptm_pkg;
  localparam int unsigned NUM_PAGES = 8;
  localparam int unsigned PAGE_W    = 8;
  localparam int unsigned LOG_AW    = 16;
  localparam int unsigned OFFS_W    = 13;
  localparam int unsigned SEL_W     = $clog2(NUM_PAGES);
  localparam int unsigned PHYS_AW   = OFFS_W + PAGE_W;
endpackage

// File: rtl/ptm_page_bank.sv
`timescale 1ns/1ps
module ptm_page_bank #(
  parameter int unsigned N         = 8,
  parameter int unsigned W         = 8,
  parameter int unsigned BOOT_IDX  = N - 1,
  parameter logic [W-1:0] BOOT_PAGE = '0,
  parameter logic [W-1:0] RST_PAGE  = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [N-1:0]          mask_i,
  input  logic [W-1:0]          wdata_i,
  output logic [N-1:0][W-1:0]   pages_o
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    localparam logic [W-1:0] RV = (g == BOOT_IDX) ? BOOT_PAGE : RST_PAGE;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                pages_o[g] <= RV;
      else if (we_i && mask_i[g]) pages_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/ptm_readback.sv
`timescale 1ns/1ps
module ptm_readback #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                re_i,
  input  logic [N-1:0]        mask_i,
  input  logic [N-1:0][W-1:0] pages_i,
  output logic [W-1:0]        rdata_o
);
  logic [W-1:0] pick;

  // scan downward so the lowest selected index wins
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) pick = pages_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= pick;
  end
endmodule

// File: rtl/ptm_xlate.sv
`timescale 1ns/1ps
module ptm_xlate #(
  parameter int unsigned N       = 8,
  parameter int unsigned W       = 8,
  parameter int unsigned LOG_AW  = 16,
  parameter int unsigned OFFS_W  = 13,
  parameter bit          REG_OUT = 1'b0,
  localparam int unsigned SEL_W  = LOG_AW - OFFS_W,
  localparam int unsigned PA_W   = OFFS_W + W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LOG_AW-1:0]   laddr_i,
  input  logic [N-1:0][W-1:0] pages_i,
  output logic [PA_W-1:0]     phys_o
);
  logic [SEL_W-1:0] win;
  logic [PA_W-1:0]  phys_c;

  assign win    = laddr_i[LOG_AW-1:OFFS_W];
  assign phys_c = {pages_i[win], laddr_i[OFFS_W-1:0]};

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) phys_o <= '0;
      else         phys_o <= phys_c;
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign phys_o = phys_c;
  end
endmodule

// File: rtl/ptm_mapper.sv
`timescale 1ns/1ps
module ptm_mapper #(
  parameter int unsigned N       = ptm_pkg::NUM_PAGES,
  parameter int unsigned W       = ptm_pkg::PAGE_W,
  parameter int unsigned LOG_AW  = ptm_pkg::LOG_AW,
  parameter int unsigned OFFS_W  = ptm_pkg::OFFS_W,
  parameter bit          REG_OUT = 1'b0,
  localparam int unsigned PA_W   = OFFS_W + W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LOG_AW-1:0] laddr_i,
  output logic [PA_W-1:0]   phys_o,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [N-1:0]      mask_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o
);
  logic [N-1:0][W-1:0] pages;

  ptm_page_bank #(.N(N), .W(W)) bank_i (
    .clk_i, .rst_ni, .we_i(wr_en_i), .mask_i, .wdata_i, .pages_o(pages)
  );

  ptm_readback #(.N(N), .W(W)) rb_i (
    .clk_i, .rst_ni, .re_i(rd_en_i), .mask_i, .pages_i(pages), .rdata_o
  );

  ptm_xlate #(.N(N), .W(W), .LOG_AW(LOG_AW), .OFFS_W(OFFS_W), .REG_OUT(REG_OUT)) xl_i (
    .clk_i, .rst_ni, .laddr_i, .pages_i(pages), .phys_o
  );
endmodule

// File: rtl/ptm_mapper_chk.sv
`timescale 1ns/1ps
module ptm_mapper_chk #(
  parameter int unsigned N       = 8,
  parameter int unsigned W       = 8,
  parameter int unsigned LOG_AW  = 16,
  parameter int unsigned OFFS_W  = 13,
  parameter bit          REG_OUT = 1'b0,
  localparam int unsigned PA_W   = OFFS_W + W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [LOG_AW-1:0]   laddr_i,
  input logic [PA_W-1:0]     phys_o,
  input logic                wr_en_i,
  input logic                rd_en_i,
  input logic [N-1:0]        mask_i,
  input logic [W-1:0]        wdata_i,
  input logic [W-1:0]        rdata_o,
  input logic [N-1:0][W-1:0] pages_i
);
  for (genvar k = 0; k < N; k++) begin : g_pg
    AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && mask_i[k]) |=> (pages_i[k] == $past(wdata_i))) else $error("load"); // R4
    AST_UNSELECTED_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && mask_i[k]) |=> $stable(pages_i[k])) else $error("keep"); // R8
  end

  AST_FETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)) else $error("hold"); // R5

  AST_EMPTY_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && mask_i == '0) |=> (rdata_o == '0)) else $error("empty"); // R6

  if (REG_OUT) begin : g_reg
    AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_i || !rd_en_i |=> (phys_o[OFFS_W-1:0] == $past(laddr_i[OFFS_W-1:0]))) else $error("offs"); // R2
  end else begin : g_comb
    AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phys_o[OFFS_W-1:0] == laddr_i[OFFS_W-1:0]) else $error("offs"); // R2
    AST_PAGE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phys_o[PA_W-1:OFFS_W] == pages_i[laddr_i[LOG_AW-1:OFFS_W]]) else $error("page"); // R3
  end
endmodule

bind ptm_mapper ptm_mapper_chk #(
  .N(N), .W(W), .LOG_AW(LOG_AW), .OFFS_W(OFFS_W), .REG_OUT(REG_OUT)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .laddr_i(laddr_i), .phys_o(phys_o),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .mask_i(mask_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .pages_i(pages)
);

// File: tb/ptm_mapper_tb_top.sv
`timescale 1ns/1ps
module ptm_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] laddr = '0;
  logic [20:0] phys;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  mask = '0, wdata = '0;
  logic [7:0]  rdata;

  int unsigned n_chk = 0, n_bad = 0;
  logic [7:0]  mdl [8];
  logic [7:0]  exp_rd = 8'h00;

  always #10 clk = ~clk;

  ptm_mapper dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .laddr_i(laddr), .phys_o(phys),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .mask_i(mask), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [20:0] exp_phys(logic [15:0] a);
    return {mdl[a[15:13]], a[12:0]};
  endfunction

  function automatic logic [7:0] lowest_sel(logic [7:0] mk);
    for (int i = 0; i < 8; i++) if (mk[i]) return mdl[i];
    return 8'h00;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // one bus cycle: drive after falling edge, check translation before the rising edge,
  // then update the model and check fetch data after it
  task automatic cyc(logic w, logic r, logic [7:0] mk, logic [7:0] d, logic [15:0] a, string req);
    @(negedge clk);
    wr_en = w; rd_en = r; mask = mk; wdata = d; laddr = a;
    #1 check({"R2 R3 ", req}, {11'b0, phys}, {11'b0, exp_phys(a)});
    @(posedge clk);
    if (r) exp_rd = lowest_sel(mk);
    if (w) for (int i = 0; i < 8; i++) if (mk[i]) mdl[i] = d;
    #1 check({"R5 ", req}, {24'b0, rdata}, {24'b0, exp_rd});
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    laddr = 16'hFFFE;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset phys", {11'b0, phys}, 32'h0000_1FFE);
    check("R1 reset rdata", {24'b0, rdata}, 32'h0);
    @(negedge clk) rst_ni = 1'b1;

    // R1: all registers zero after reset
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, 8'(1 << i), 8'h00, {3'(i), 13'h0ABC}, "R1 post-reset");

    // R4: multi-register load
    cyc(1'b1, 1'b0, 8'hA5, 8'h3C, 16'h1234, "R4 multi load");
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, 8'(1 << i), 8'h00, {3'(i), 13'h1FFF}, "R4 readback");

    // R8: ignored loads
    cyc(1'b0, 1'b0, 8'hFF, 8'h77, 16'h0000, "R8 strobe low");
    cyc(1'b1, 1'b0, 8'h00, 8'h99, 16'hE000, "R8 empty mask");
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, 8'(1 << i), 8'h00, {3'(i), 13'h0001}, "R8 readback");

    // R6: empty fetch
    cyc(1'b1, 1'b0, 8'h02, 8'hC3, 16'h4000, "R6 prep");
    cyc(1'b0, 1'b1, 8'h02, 8'h00, 16'h2000, "R6 prep fetch");
    cyc(1'b0, 1'b1, 8'h00, 8'h00, 16'h2000, "R6 empty fetch");
    check("R6 zero", {24'b0, rdata}, 32'h0);

    // R5: lowest selected wins, hold when strobe low
    cyc(1'b0, 1'b1, 8'hA4, 8'h00, 16'hA000, "R5 lowest of multi");
    check("R5 lowest is reg2", {24'b0, rdata}, 32'h3C);
    cyc(1'b0, 1'b0, 8'h01, 8'h00, 16'hA000, "R5 hold");

    // R7: load and fetch on the same register in one cycle
    cyc(1'b1, 1'b1, 8'h08, 8'h5A, 16'h6123, "R7 collision");
    check("R7 old value fetched", {24'b0, rdata}, 32'h0);
    cyc(1'b0, 1'b0, 8'h00, 8'h00, 16'h6123, "R7 next cycle");
    check("R7 new page used", {11'b0, phys}, 32'h000B_4123);

    // R2 boundaries
    cyc(1'b1, 1'b0, 8'hFF, 8'hFF, 16'h0000, "R2 all pages FF");
    cyc(1'b0, 1'b0, 8'h00, 8'h00, 16'h1FFF, "R2 top of window");
    cyc(1'b0, 1'b0, 8'h00, 8'h00, 16'hFFFF, "R2 top of space");
    check("R2 R3 max phys", {11'b0, phys}, 32'h001F_FFFF);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] mk;
      mk = ($urandom % 3 == 0) ? 8'(1 << ($urandom % 8)) : 8'($urandom);
      cyc(1'($urandom), 1'($urandom), mk, 8'($urandom), 16'($urandom), "R4 R7 random");
    end

    summary();
    $finish;
  end
endmodule